// File: doc/BRIEF.md
# Write-Unlock Sequencer

This block stands in front of a page-load controller and decides, one write at a time, whether a decoded write event may reach the page buffer. Protection is off after reset, and writes then flow straight through. A fixed three-write key sequence opens a page window. Completing that sequence also arms protection, and protection stays armed until a disarm sequence is written. While protection is armed, only writes inside an open window reach the page controller. Everything else is dropped.

The window accepts up to `PAGE_BYTES` data writes. It closes when the page controller reports that programming has started, and the guard then relocks. Key writes are consumed by the sequencer and never forwarded. The key addresses and data values are parameters. The disarm sequence reuses the first two key steps and then writes `OFF_DATA` to the third key address.

Both the write input and the write output are valid/ready streams. A write that is forwarded takes its `in_ready` from `out_ready`, so back-pressure from the page controller stalls it. A write that is consumed or dropped is accepted in the cycle it is presented, whatever `out_ready` is. Upstream must hold `in_valid`, `in_addr` and `in_data` until the write is accepted.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset, protection is off, no write is dropped, and a plain write appears on `out_*` with its address and data unchanged.
- R2: A forwarded write holds `in_ready` low and `out_valid` high with the same address while `out_ready` is low. A dropped or consumed write is accepted in its first cycle even with `out_ready` low.
- R3: Writing key steps 0, 1 and 2 in that order (`KEY0_ADDR`/`KEY0_DATA`, then step 1, then step 2) consumes each of the three writes. A consumed write raises neither `out_valid` nor `drop`.
- R4: Completing the key sequence arms protection and opens a window in which the next `PAGE_BYTES` writes are forwarded.
- R5: Once a window already holds `PAGE_BYTES` writes, further writes in that window are dropped.
- R6: A `commit` pulse while the window is open closes it. Protection stays armed, so the next plain write is dropped.
- R7: While protection is armed and no window is open, a non-key write is dropped: `drop` pulses and `out_valid` stays low.
- R8: A write that is not the expected next key step resets the sequence to its start. That write is dropped if protection is armed and forwarded if it is not. A later step-1 write alone is then not accepted as progress.
- R9: Key steps 0 and 1 followed by `OFF_DATA` at `KEY2_ADDR` are consumed and disarm protection, so plain writes pass again.
- R10: A write presented in the same cycle as `commit` in an open window is dropped, and the window closes.
- R11: `commit` outside an open window has no effect. Plain writes keep their verdict, and partial key progress is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Write event valid |
| in_ready | output | 1 | Write event accepted |
| in_addr | input | ADDR_W | Write address |
| in_data | input | DATA_W | Write data |
| out_valid | output | 1 | Forwarded write valid |
| out_ready | input | 1 | Page controller can take a write |
| out_addr | output | ADDR_W | Forwarded address |
| out_data | output | DATA_W | Forwarded data |
| drop | output | 1 | Pulses when an accepted write is discarded |
| commit | input | 1 | Page programming has started |

## Verification
A window write and the `commit` pulse can land in the same cycle. The bench provokes this by driving the last write of a window together with `commit` at one clock edge. The scoreboard must then see that write as a drop, not a forward, and a plain write that follows must also be dropped. A second collision comes from stalling a forwarded write with `out_ready` low and then presenting writes that are dropped with `out_ready` still low. This shows that back-pressure only ever holds forwarded writes.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int KEY_STEPS = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_OPEN
  } wp_state_e;

  typedef enum logic [1:0] {
    VD_PASS,
    VD_DROP,
    VD_EAT
  } wp_verdict_e;
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match
  import wp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [KEY_STEPS-1:0][ADDR_W-1:0] KEY_ADDR = '0,
  parameter logic [KEY_STEPS-1:0][DATA_W-1:0] KEY_DATA = '0,
  parameter logic [DATA_W-1:0] OFF_DATA = '0
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    data,
  output logic [KEY_STEPS-1:0] step_hit,
  output logic                 off_hit
);
  for (genvar g = 0; g < KEY_STEPS; g++) begin : g_step
    assign step_hit[g] = (addr == KEY_ADDR[g]) && (data == KEY_DATA[g]);
  end

  assign off_hit = (addr == KEY_ADDR[KEY_STEPS-1]) && (data == OFF_DATA);
endmodule

// File: rtl/wp_window_ctr.sv
module wp_window_ctr #(
  parameter int PAGE_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PAGE_BYTES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign full = (cnt == LIMIT);

  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !full); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT); // R4
endmodule

// File: rtl/wp_protect_flag.sv
module wp_protect_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (arm)    armed <= 1'b1;
    else if (disarm) armed <= 1'b0;
  end

  AST_ARM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm && disarm)); // R9
  AST_DISARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !armed); // R9
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 13'h1555,
  parameter logic [DATA_W-1:0] KEY0_DATA = 8'hAA,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 13'h0AAA,
  parameter logic [DATA_W-1:0] KEY1_DATA = 8'h55,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 13'h1555,
  parameter logic [DATA_W-1:0] KEY2_DATA = 8'hA0,
  parameter logic [DATA_W-1:0] OFF_DATA  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              drop,
  input  logic              commit
);
  localparam logic [KEY_STEPS-1:0][ADDR_W-1:0] KADDR = {KEY2_ADDR, KEY1_ADDR, KEY0_ADDR};
  localparam logic [KEY_STEPS-1:0][DATA_W-1:0] KDATA = {KEY2_DATA, KEY1_DATA, KEY0_DATA};

  wp_state_e            state, state_d, nxt;
  wp_verdict_e          verdict, blocked;
  logic [KEY_STEPS-1:0] step_hit;
  logic                 off_hit, armed, full, take;
  logic                 arm_req, disarm_req, clr_req, inc_req;

  wp_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KADDR), .KEY_DATA(KDATA), .OFF_DATA(OFF_DATA)
  ) i_match (
    .addr(in_addr), .data(in_data), .step_hit(step_hit), .off_hit(off_hit)
  );

  wp_protect_flag i_flag (
    .clk(clk), .rst_n(rst_n),
    .arm(take && arm_req), .disarm(take && disarm_req), .armed(armed)
  );

  wp_window_ctr #(.PAGE_BYTES(PAGE_BYTES)) i_ctr (
    .clk(clk), .rst_n(rst_n),
    .clr(take && clr_req), .inc(take && inc_req), .full(full)
  );

  // Verdict and next step for the write presented this cycle.
  always_comb begin
    blocked    = armed ? VD_DROP : VD_PASS;
    verdict    = blocked;
    nxt        = state;
    arm_req    = 1'b0;
    disarm_req = 1'b0;
    clr_req    = 1'b0;
    inc_req    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (step_hit[0]) begin
          verdict = VD_EAT;
          nxt     = ST_KEY1;
        end
      end
      ST_KEY1: begin
        nxt = ST_IDLE;
        if (step_hit[1]) begin
          verdict = VD_EAT;
          nxt     = ST_KEY2;
        end
      end
      ST_KEY2: begin
        nxt = ST_IDLE;
        if (step_hit[2]) begin
          verdict = VD_EAT;
          nxt     = ST_OPEN;
          arm_req = 1'b1;
          clr_req = 1'b1;
        end else if (off_hit) begin
          verdict    = VD_EAT;
          disarm_req = 1'b1;
        end
      end
      ST_OPEN: begin
        if (commit) begin
          verdict = VD_DROP;
          nxt     = ST_IDLE;
        end else if (full) begin
          verdict = VD_DROP;
        end else begin
          verdict = VD_PASS;
          inc_req = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign in_ready  = (verdict == VD_PASS) ? out_ready : 1'b1;
  assign take      = in_valid && in_ready;
  assign out_valid = in_valid && (verdict == VD_PASS);
  assign drop      = in_valid && (verdict == VD_DROP);
  assign out_addr  = in_addr;
  assign out_data  = in_data;

  always_comb begin
    if (state == ST_OPEN && commit) state_d = ST_IDLE;
    else if (take)                  state_d = nxt;
    else                            state_d = state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && drop)); // R7
  AST_GUARDED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && armed) |-> (state == ST_OPEN)); // R7
  AST_COMMIT_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN && commit) |=> (state == ST_IDLE)); // R6
  AST_ARM_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(state) == ST_KEY2)); // R4
  AST_KEY_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && state == ST_KEY2 && step_hit[2]) |-> !out_valid); // R3
  AST_COMMIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && state == ST_OPEN && commit) |-> (drop && in_ready)); // R10
endmodule

// File: tb/test_wp_unlock_seq.sv
module test_wp_unlock_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] KA0 = 13'h1555;
  localparam logic [7:0]  KD0 = 8'hAA;
  localparam logic [12:0] KA1 = 13'h0AAA;
  localparam logic [7:0]  KD1 = 8'h55;
  localparam logic [12:0] KA2 = 13'h1555;
  localparam logic [7:0]  KD2 = 8'hA0;
  localparam logic [7:0]  OFF = 8'h20;
  localparam int K_PASS = 0;
  localparam int K_DROP = 1;
  localparam int K_EAT  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [12:0] in_addr = '0;
  logic [7:0]  in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [12:0] out_addr;
  logic [7:0]  out_data;
  logic drop;
  logic commit = 1'b0;

  int checks = 0;
  int errors = 0;
  bit summary_done = 1'b0;

  int          q_kind[$];
  logic [12:0] q_addr[$];
  logic [7:0]  q_data[$];
  string       q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_unlock_seq i_wp_unlock_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .drop(drop), .commit(commit)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: each accepted write is compared against the next expected item.
  always @(negedge clk) begin
    if (rst_n && in_valid && in_ready) begin
      int got;
      got = out_valid ? K_PASS : (drop ? K_DROP : K_EAT);
      if (q_kind.size() == 0) begin
        chk(1'b0, "SB", "unexpected write verdict", got, -1);
      end else begin
        int e_kind;
        logic [12:0] e_addr;
        logic [7:0]  e_data;
        string e_req;
        e_kind = q_kind.pop_front();
        e_addr = q_addr.pop_front();
        e_data = q_data.pop_front();
        e_req  = q_req.pop_front();
        chk(got == e_kind, e_req, "verdict", got, e_kind);
        if (e_kind == K_PASS) begin
          chk(out_addr == e_addr && out_data == e_data, e_req, "forwarded addr/data",
              int'({out_addr, out_data}), int'({e_addr, e_data}));
        end
      end
    end
  end

  // Driver: present one write, optionally with commit in the same cycle.
  task automatic send(input logic [12:0] a, input logic [7:0] d, input int kind,
                      input string req, input bit with_commit);
    bit done;
    q_kind.push_back(kind);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_req.push_back(req);
    in_addr  = a;
    in_data  = d;
    in_valid = 1'b1;
    commit   = with_commit;
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      done = in_ready;
      if (!done) begin
        @(posedge clk);
        #1;
      end
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    commit   = 1'b0;
  endtask

  task automatic pulse_commit();
    commit = 1'b1;
    @(posedge clk);
    #1;
    commit = 1'b0;
  endtask

  task automatic unlock(input string req);
    send(KA0, KD0, K_EAT, req, 1'b0);
    send(KA1, KD1, K_EAT, req, 1'b0);
    send(KA2, KD2, K_EAT, req, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && drop == 1'b0, "R1", "idle outputs after reset",
        int'({out_valid, drop}), 0);
    @(posedge clk);
    #1;

    // R1 and R2: plain write passes, stalled while out_ready is low.
    out_ready = 1'b0;
    fork
      send(13'h0123, 8'h3C, K_PASS, "R1", 1'b0);
      begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R2", "in_ready follows low out_ready", int'(in_ready), 0);
        chk(out_valid == 1'b1 && out_addr == 13'h0123, "R2", "held forward valid",
            int'(out_valid), 1);
        #1 out_ready = 1'b1;
      end
    join

    // R11: commit outside a window changes nothing.
    pulse_commit();
    send(13'h0200, 8'h01, K_PASS, "R11", 1'b0);

    // R8: unprotected mismatch after step 0 is forwarded.
    send(KA0, KD0, K_EAT, "R8", 1'b0);
    send(13'h0222, 8'h11, K_PASS, "R8", 1'b0);

    // R3 and R11: key sequence with a stray commit in the middle.
    send(KA0, KD0, K_EAT, "R3", 1'b0);
    pulse_commit();
    send(KA1, KD1, K_EAT, "R11", 1'b0);
    send(KA2, KD2, K_EAT, "R3", 1'b0);

    // R4 and R5: fill the window, then one write too many.
    for (int i = 0; i < 64; i++) begin
      send(13'(13'h0400 + i), 8'(i) ^ 8'h5A, K_PASS, "R4", 1'b0);
    end
    send(13'h0440, 8'hEE, K_DROP, "R5", 1'b0);

    // R6: commit closes the window; R2: a drop is accepted with out_ready low.
    pulse_commit();
    out_ready = 1'b0;
    send(13'h0500, 8'h77, K_DROP, "R6", 1'b0);
    send(13'h0501, 8'h78, K_DROP, "R7", 1'b0);
    out_ready = 1'b1;

    // R8: protected mismatch is dropped and the sequence starts over.
    send(KA0, KD0, K_EAT, "R8", 1'b0);
    send(13'h0222, 8'h33, K_DROP, "R8", 1'b0);
    send(KA1, KD1, K_DROP, "R8", 1'b0);

    // R10: a write in the same cycle as commit is dropped.
    unlock("R3");
    send(13'h0600, 8'h10, K_PASS, "R4", 1'b0);
    send(13'h0601, 8'h11, K_PASS, "R4", 1'b0);
    send(13'h0602, 8'h12, K_DROP, "R10", 1'b1);
    send(13'h0603, 8'h13, K_DROP, "R10", 1'b0);

    // R9: disarm sequence, then plain writes pass.
    send(KA0, KD0, K_EAT, "R9", 1'b0);
    send(KA1, KD1, K_EAT, "R9", 1'b0);
    send(KA2, OFF, K_EAT, "R9", 1'b0);
    send(13'h0700, 8'h99, K_PASS, "R9", 1'b0);
    send(13'h0701, 8'h9A, K_PASS, "R1", 1'b0);

    repeat (2) @(negedge clk);
    chk(q_kind.size() == 0, "SB", "all expected items seen", q_kind.size(), 0);
    finish_run();
  end
endmodule